// File: doc/BRIEF.md
# Multi-Endpoint Slave FIFO Interface

This block sits on the peripheral side of a link to an external bus master. The master reaches it through an interface clocked by `clk_i`, using active-low strobes: a 16-bit data bus, a 3-bit port address, chip select, output enable, read, write and packet-end. Address values 0 to 3 pick one of four endpoint FIFOs, which are carved out of a single 2048 x 16-bit buffer of 512 words each. Address 4 picks a command port that holds a small register file and a latched interrupt status byte. The three flag outputs always describe whatever the address currently selects.

Endpoints 0 and 1 carry data from the USB side to the master; they are OUT endpoints. Endpoints 2 and 3 carry data from the master to the USB side; they are IN endpoints. On the USB side, one push port and one pop port share an endpoint select. Words the master writes into an IN endpoint stay invisible to the USB side until the master asserts packet-end. Six event inputs from the USB side feed the interrupt logic. Each event is gated by an enable bit.

When an interrupt is pending, a read of the command port returns the status byte directly, with no prior read request. That read clears the status.

Top module: `slave_fifo_if`

## Requirements
- R1: Address decode.
  - `addr_i` 0, 1, 2 and 3 select endpoints 0 to 3, and 4 selects the command port.
  - Addresses 5 to 7 read as 0x0000, drive all three flags low, and ignore writes.
- R2: `data_oe_o` is high only while `cs_ni` and `oe_ni` are both low. Otherwise `data_o` is 0.
- R3: IN endpoints (2 and 3).
  - Each rising edge with chip select and `wr_ni` low stores `data_i` and advances the write pointer.
  - After commit, the USB side pops the words in write order. `usb_data_o` shows the head word, and each `usb_pop_i` edge advances it.
- R4: OUT endpoints (0 and 1).
  - `usb_push_i` stores `usb_data_i`.
  - While chip select and `oe_ni` are low, `data_o` shows the head word. Each edge with `rd_ni` also low pops one word, and output enable alone does not advance.
- R5: Packet-end commit.
  - For an IN endpoint, `usb_ready_o` stays low while it holds only uncommitted words.
  - An edge with chip select and `pkt_end_ni` low commits every word written so far, and `usb_ready_o` rises after that edge.
  - For an OUT endpoint, `usb_ready_o` means not full.
- R6: Flags.
  - With an endpoint selected, `flag_a_o` = (word count >= threshold), `flag_b_o` = full (512 words) and `flag_c_o` = empty.
  - With the command port selected, the flags are A=1, B=0, C=0.
- R7: A write to a full FIFO and a read from an empty FIFO are ignored. They leave the stored data and the pointers unchanged.
- R8: Command register 1 holds the level threshold. Its reset value is 256 (half of 512), and it is writable.
- R9: Command port writes.
  - Command word fields: bit 15 is the request flag, bits [14:12] the register index and bits [11:0] the value.
  - With bit 15 = 0, the value is stored in the indexed register.
  - With bit 15 = 1, the indexed register is chosen for reading. Later command reads return it zero-extended while no interrupt is pending.
- R10: Interrupt set.
  - Register 0 bits [5:0] enable the event inputs `usb_event_i[5:0]`; their reset value is 0.
  - An enabled event sets its status bit, and `int_no` goes low after that edge.
  - A disabled event has no effect.
- R11: Status read and clear.
  - While `int_no` is low, a command port read returns the status byte on bits [7:0], with bits [15:8] zero.
  - The read-strobe edge clears the status and raises `int_no`, unless an enabled event arrives on that same edge.
- R12: Reset state.
  - All FIFOs are empty and `int_no` is high.
  - With endpoint 0 selected, the flags are A=0, B=0, C=1, and `usb_ready_o` for endpoint 0 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Output enable, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| pkt_end_ni | input | 1 | Packet-end commit, active low |
| addr_i | input | 3 | Port select: endpoints 0-3, command port 4 |
| data_i | input | 16 | Master write data |
| data_o | output | 16 | Master read data |
| data_oe_o | output | 1 | Data bus drive enable |
| flag_a_o | output | 1 | Level flag of the selected port |
| flag_b_o | output | 1 | Full flag of the selected port |
| flag_c_o | output | 1 | Empty flag of the selected port |
| int_no | output | 1 | Interrupt, active low |
| usb_ep_i | input | 2 | USB-side endpoint select |
| usb_push_i | input | 1 | USB-side push into an OUT endpoint |
| usb_pop_i | input | 1 | USB-side pop from an IN endpoint |
| usb_data_i | input | 16 | USB-side push data |
| usb_data_o | output | 16 | USB-side head word |
| usb_ready_o | output | 1 | USB side may push (OUT endpoint) or pop (IN endpoint) |
| usb_event_i | input | 6 | Interrupt event pulses |

## Verification
Suppose a pointer is off by one, a commit pointer is stale, or two endpoints are crossed. The head word at `data_o` or `usb_data_o` is then wrong from the very next pop, or a flag is wrong on the first sample after the faulty edge. A full-buffer run and a drain through the USB side expose counting errors at the 512-word boundary: a dropped guard would overwrite the oldest word, and that shows as a mismatch on the first pop. Interrupt status faults appear one edge after the event, or after the clearing read, as a wrong `int_no` level or a wrong status byte.

// File: rtl/slave_fifo_pkg.sv
package slave_fifo_pkg;
  localparam int unsigned NUM_EP   = 4;
  localparam int unsigned EP_IDX_W = 2;
  localparam logic [2:0]  CMD_ADDR = 3'd4;
  localparam int unsigned NUM_IRQ  = 6;
  localparam int unsigned REG_IDX_W = 3;
  localparam int unsigned REG_VAL_W = 12;

  typedef struct packed {
    logic level;
    logic full;
    logic empty;
  } ep_flags_t;
endpackage

// File: rtl/slave_fifo_buf.sv
module slave_fifo_buf #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              a_we_i,
  input  logic [ADDR_W-1:0] a_waddr_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  input  logic [ADDR_W-1:0] a_raddr_i,
  output logic [DATA_W-1:0] a_rdata_o,
  input  logic              b_we_i,
  input  logic [ADDR_W-1:0] b_waddr_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  input  logic [ADDR_W-1:0] b_raddr_i,
  output logic [DATA_W-1:0] b_rdata_o
);
  localparam int unsigned WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [WORDS];

  // Ports only ever target different endpoints, so the addresses never collide
  always_ff @(posedge clk_i) begin
    if (a_we_i) mem_q[a_waddr_i] <= a_wdata_i;
    if (b_we_i) mem_q[b_waddr_i] <= b_wdata_i;
  end

  assign a_rdata_o = mem_q[a_raddr_i];
  assign b_rdata_o = mem_q[b_raddr_i];
endmodule

// File: rtl/slave_fifo_ep.sv
module slave_fifo_ep
  import slave_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned THR_W = 12,
  parameter bit          IS_IN = 1'b0,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             m_wr_i,
  input  logic             m_rd_i,
  input  logic             m_commit_i,
  input  logic             u_push_i,
  input  logic             u_pop_i,
  input  logic [THR_W-1:0] thresh_i,
  output logic             push_o,
  output logic             pop_o,
  output logic [AW-1:0]    wr_ptr_o,
  output logic [AW-1:0]    rd_ptr_o,
  output logic             usb_ready_o,
  output ep_flags_t        flags_o
);
  logic [PW-1:0] wptr_q, rptr_q, cptr_q;
  logic [PW-1:0] count;
  logic          full, empty, has_commit;
  logic          push_req, pop_req, commit_req;

  assign count      = wptr_q - rptr_q;
  assign full       = (count == PW'(DEPTH));
  assign empty      = (count == '0);
  assign has_commit = (cptr_q != rptr_q);

  // Producer and consumer sides swap with the endpoint direction
  assign push_req   = IS_IN ? m_wr_i  : u_push_i;
  assign pop_req    = IS_IN ? u_pop_i : m_rd_i;
  assign commit_req = IS_IN ? m_commit_i : 1'b1;

  assign push_o = push_req & ~full;
  assign pop_o  = pop_req & has_commit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cptr_q <= '0;
    end else begin
      if (push_o)     wptr_q <= wptr_q + 1'b1;
      if (pop_o)      rptr_q <= rptr_q + 1'b1;
      if (commit_req) cptr_q <= wptr_q + PW'(push_o);
    end
  end

  assign wr_ptr_o      = wptr_q[AW-1:0];
  assign rd_ptr_o      = rptr_q[AW-1:0];
  assign usb_ready_o   = IS_IN ? has_commit : ~full;
  assign flags_o.level = (32'(count) >= 32'(thresh_i));
  assign flags_o.full  = full;
  assign flags_o.empty = empty;
endmodule

// File: rtl/slave_fifo_cmd.sv
module slave_fifo_cmd
  import slave_fifo_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned N_IRQ   = NUM_IRQ,
  parameter int unsigned IDX_W   = REG_IDX_W,
  parameter int unsigned VAL_W   = REG_VAL_W,
  parameter int unsigned THR_RST = 256,
  localparam int unsigned N_REG  = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N_IRQ-1:0]  event_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [VAL_W-1:0]  thresh_o,
  output logic [N_IRQ-1:0]  irq_en_o,
  output logic              int_no
);
  logic [VAL_W-1:0] regs_q [N_REG];
  logic [IDX_W-1:0] rsel_q;
  logic [N_IRQ-1:0] status_q, status_d, set_bits;
  logic             pend, is_req;
  logic [IDX_W-1:0] idx;

  assign is_req = wdata_i[DATA_W-1];
  assign idx    = wdata_i[DATA_W-2 -: IDX_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(N_REG); i++) regs_q[i] <= '0;
      regs_q[1] <= VAL_W'(THR_RST);
      rsel_q    <= '0;
    end else if (wr_i) begin
      if (is_req) rsel_q <= idx;
      else        regs_q[idx] <= wdata_i[VAL_W-1:0];
    end
  end

  assign irq_en_o = regs_q[0][N_IRQ-1:0];
  assign thresh_o = regs_q[1];
  assign pend     = |status_q;
  assign set_bits = event_i & irq_en_o;

  // A new event on the clearing edge wins over the clear
  always_comb begin
    status_d = status_q | set_bits;
    if (rd_i && pend) status_d = set_bits;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= status_d;
  end

  assign int_no  = ~pend;
  assign rdata_o = pend ? DATA_W'(status_q) : DATA_W'(regs_q[rsel_q]);
endmodule

// File: rtl/slave_fifo_if.sv
module slave_fifo_if
  import slave_fifo_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned EP_DEPTH    = 512,
  parameter logic [3:0]  EP_IN_MASK  = 4'b1100,
  localparam int unsigned AW         = $clog2(EP_DEPTH),
  localparam int unsigned BAW        = AW + EP_IDX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  logic               oe_ni,
  input  logic               rd_ni,
  input  logic               wr_ni,
  input  logic               pkt_end_ni,
  input  logic [2:0]         addr_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic [DATA_W-1:0]  data_o,
  output logic               data_oe_o,
  output logic               flag_a_o,
  output logic               flag_b_o,
  output logic               flag_c_o,
  output logic               int_no,
  input  logic [1:0]         usb_ep_i,
  input  logic               usb_push_i,
  input  logic               usb_pop_i,
  input  logic [DATA_W-1:0]  usb_data_i,
  output logic [DATA_W-1:0]  usb_data_o,
  output logic               usb_ready_o,
  input  logic [NUM_IRQ-1:0] usb_event_i
);
  logic                  sel, to_ep, to_cmd;
  logic [EP_IDX_W-1:0]   ep_idx;
  logic [NUM_EP-1:0]     m_wr, m_rd, m_commit, u_push, u_pop;
  logic [NUM_EP-1:0]     push, pop, ready;
  logic [AW-1:0]         wptr [NUM_EP];
  logic [AW-1:0]         rptr [NUM_EP];
  ep_flags_t             flags [NUM_EP];
  logic [REG_VAL_W-1:0]  thresh;
  logic [NUM_IRQ-1:0]    irq_en;
  logic [DATA_W-1:0]     cmd_rdata, m_head, rd_mux;
  logic                  m_we, u_we;

  assign sel    = ~cs_ni;
  assign ep_idx = addr_i[EP_IDX_W-1:0];
  assign to_ep  = sel & ~addr_i[2];
  assign to_cmd = sel & (addr_i == CMD_ADDR);

  for (genvar g = 0; g < int'(NUM_EP); g++) begin : g_ep
    assign m_wr[g]     = to_ep & ~wr_ni      & (ep_idx == g);
    assign m_rd[g]     = to_ep & ~rd_ni      & (ep_idx == g);
    assign m_commit[g] = to_ep & ~pkt_end_ni & (ep_idx == g);
    assign u_push[g]   = usb_push_i & (usb_ep_i == g);
    assign u_pop[g]    = usb_pop_i  & (usb_ep_i == g);

    slave_fifo_ep #(
      .DEPTH (EP_DEPTH),
      .THR_W (REG_VAL_W),
      .IS_IN (EP_IN_MASK[g])
    ) u_ep (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .m_wr_i      (m_wr[g]),
      .m_rd_i      (m_rd[g]),
      .m_commit_i  (m_commit[g]),
      .u_push_i    (u_push[g]),
      .u_pop_i     (u_pop[g]),
      .thresh_i    (thresh),
      .push_o      (push[g]),
      .pop_o       (pop[g]),
      .wr_ptr_o    (wptr[g]),
      .rd_ptr_o    (rptr[g]),
      .usb_ready_o (ready[g]),
      .flags_o     (flags[g])
    );
  end

  assign m_we = |(push & EP_IN_MASK);
  assign u_we = |(push & ~EP_IN_MASK);

  slave_fifo_buf #(
    .DATA_W (DATA_W),
    .ADDR_W (BAW)
  ) u_buf (
    .clk_i     (clk_i),
    .a_we_i    (m_we),
    .a_waddr_i ({ep_idx, wptr[ep_idx]}),
    .a_wdata_i (data_i),
    .a_raddr_i ({ep_idx, rptr[ep_idx]}),
    .a_rdata_o (m_head),
    .b_we_i    (u_we),
    .b_waddr_i ({usb_ep_i, wptr[usb_ep_i]}),
    .b_wdata_i (usb_data_i),
    .b_raddr_i ({usb_ep_i, rptr[usb_ep_i]}),
    .b_rdata_o (usb_data_o)
  );

  slave_fifo_cmd #(
    .DATA_W  (DATA_W),
    .THR_RST (EP_DEPTH / 2)
  ) u_cmd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (to_cmd & ~wr_ni),
    .rd_i     (to_cmd & ~rd_ni),
    .wdata_i  (data_i),
    .event_i  (usb_event_i),
    .rdata_o  (cmd_rdata),
    .thresh_o (thresh),
    .irq_en_o (irq_en),
    .int_no   (int_no)
  );

  always_comb begin
    rd_mux = '0;
    {flag_a_o, flag_b_o, flag_c_o} = 3'b000;
    if (!addr_i[2]) begin
      rd_mux = EP_IN_MASK[ep_idx] ? '0 : m_head;
      {flag_a_o, flag_b_o, flag_c_o} = flags[ep_idx];
    end else if (addr_i == CMD_ADDR) begin
      rd_mux = cmd_rdata;
      {flag_a_o, flag_b_o, flag_c_o} = 3'b100;
    end
  end

  assign data_oe_o   = sel & ~oe_ni;
  assign data_o      = data_oe_o ? rd_mux : '0;
  assign usb_ready_o = ready[usb_ep_i];
endmodule

// File: rtl/slave_fifo_if_chk.sv
module slave_fifo_if_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_ni,
  input logic       rd_ni,
  input logic [2:0] addr_i,
  input logic       data_oe_o,
  input logic       flag_a_o,
  input logic       flag_b_o,
  input logic       flag_c_o,
  input logic       int_no,
  input logic [5:0] usb_event_i,
  input logic [5:0] irq_en
);
  // R2
  oe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !data_oe_o);

  // R6
  full_empty_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_i[2] |-> !(flag_b_o && flag_c_o));

  // R1
  unmapped_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i > 3'd4) |-> !(flag_a_o || flag_b_o || flag_c_o));

  // R10
  irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(usb_event_i & irq_en)) |=> !int_no);

  // R11
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && addr_i == 3'd4 && !rd_ni && !int_no && !(|(usb_event_i & irq_en)))
      |=> int_no);
endmodule

bind slave_fifo_if slave_fifo_if_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_ni       (cs_ni),
  .rd_ni       (rd_ni),
  .addr_i      (addr_i),
  .data_oe_o   (data_oe_o),
  .flag_a_o    (flag_a_o),
  .flag_b_o    (flag_b_o),
  .flag_c_o    (flag_c_o),
  .int_no      (int_no),
  .usb_event_i (usb_event_i),
  .irq_en      (irq_en)
);

// File: tb/slave_fifo_if_tb_top.sv
`timescale 1ns/1ps
module slave_fifo_if_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cs_ni = 1'b1, oe_ni = 1'b1, rd_ni = 1'b1, wr_ni = 1'b1, pkt_end_ni = 1'b1;
  logic [2:0]  addr_i = '0;
  logic [15:0] data_i = '0, data_o;
  logic        data_oe_o, flag_a_o, flag_b_o, flag_c_o, int_no;
  logic [1:0]  usb_ep_i = '0;
  logic        usb_push_i = 1'b0, usb_pop_i = 1'b0;
  logic [15:0] usb_data_i = '0, usb_data_o;
  logic        usb_ready_o;
  logic [5:0]  usb_event_i = '0;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  slave_fifo_if dut_i (.*);

  // {read, addr, data, expected}
  localparam int NV = 14;
  localparam logic [35:0] VEC [NV] = '{
    {1'b0, 3'd4, 16'h9000, 16'h0000},
    {1'b1, 3'd4, 16'h0000, 16'h0100},
    {1'b0, 3'd4, 16'h1005, 16'h0000},
    {1'b0, 3'd4, 16'h9000, 16'h0000},
    {1'b1, 3'd4, 16'h0000, 16'h0005},
    {1'b0, 3'd4, 16'h3ABC, 16'h0000},
    {1'b0, 3'd4, 16'hB000, 16'h0000},
    {1'b1, 3'd4, 16'h0000, 16'h0ABC},
    {1'b0, 3'd5, 16'h3123, 16'h0000},
    {1'b1, 3'd5, 16'h0000, 16'h0000},
    {1'b1, 3'd4, 16'h0000, 16'h0ABC},
    {1'b0, 3'd4, 16'h7055, 16'h0000},
    {1'b0, 3'd4, 16'hF000, 16'h0000},
    {1'b1, 3'd4, 16'h0000, 16'h0055}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk_i);
    addr_i = a; data_i = d; cs_ni = 1'b0; wr_ni = 1'b0;
    @(negedge clk_i);
    cs_ni = 1'b1; wr_ni = 1'b1;
  endtask

  task automatic bus_read(input logic [2:0] a, input logic pop, output logic [15:0] d);
    @(negedge clk_i);
    addr_i = a; cs_ni = 1'b0; oe_ni = 1'b0; rd_ni = ~pop;
    #1 d = data_o;
    @(negedge clk_i);
    cs_ni = 1'b1; oe_ni = 1'b1; rd_ni = 1'b1;
  endtask

  task automatic commit(input logic [2:0] a);
    @(negedge clk_i);
    addr_i = a; cs_ni = 1'b0; pkt_end_ni = 1'b0;
    @(negedge clk_i);
    cs_ni = 1'b1; pkt_end_ni = 1'b1;
  endtask

  task automatic usb_push(input logic [1:0] ep, input logic [15:0] d);
    @(negedge clk_i);
    usb_ep_i = ep; usb_data_i = d; usb_push_i = 1'b1;
    @(negedge clk_i);
    usb_push_i = 1'b0;
  endtask

  task automatic usb_event(input logic [5:0] ev);
    @(negedge clk_i);
    usb_event_i = ev;
    @(negedge clk_i);
    usb_event_i = '0;
    #1;
  endtask

  initial begin
    repeat (1000) @(posedge clk_i);
    if (!done) begin
      repeat (189000) @(posedge clk_i);
      if (!done) begin
        checks++; failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] rd;
    int          bad;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1;
    // R12 reset state
    check("R12 flags", {flag_a_o, flag_b_o, flag_c_o}, 3'b001);
    check("R12 int_no", int_no, 1'b1);
    check("R12 usb_ready ep0", usb_ready_o, 1'b1);
    check("R2 idle oe", data_oe_o, 1'b0);

    // Register file vectors: R1, R8, R9
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][35]) begin
        bus_read(VEC[i][34:32], 1'b1, rd);
        check($sformatf("R1/R8/R9 vec %0d", i), rd, VEC[i][15:0]);
      end else begin
        bus_write(VEC[i][34:32], VEC[i][31:16]);
      end
    end

    // R2: chip select gates the drive
    @(negedge clk_i);
    addr_i = 3'd4; oe_ni = 1'b0; cs_ni = 1'b1;
    #1 check("R2 oe without cs", {data_oe_o, data_o}, 17'h0);
    cs_ni = 1'b0;
    #1 check("R2 oe with cs", data_oe_o, 1'b1);
    cs_ni = 1'b1; oe_ni = 1'b1;

    // R6 command and unmapped flag meaning, R1
    #1 check("R6 cmd flags", {flag_a_o, flag_b_o, flag_c_o}, 3'b100);
    addr_i = 3'd5;
    #1 check("R1 unmapped flags", {flag_a_o, flag_b_o, flag_c_o}, 3'b000);

    // R3 and R5 on endpoint 2 (IN)
    bus_write(3'd2, 16'hA001);
    bus_write(3'd2, 16'hA002);
    bus_write(3'd2, 16'hA003);
    usb_ep_i = 2'd2;
    #1 check("R5 uncommitted not ready", usb_ready_o, 1'b0);
    commit(3'd2);
    #1 check("R5 committed ready", usb_ready_o, 1'b1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      #1 check("R3 usb pop order", usb_data_o, 16'hA001 + 16'(k));
      usb_pop_i = 1'b1;
      @(negedge clk_i);
      usb_pop_i = 1'b0;
    end
    #1 check("R3 drained", usb_ready_o, 1'b0);

    // R4 on endpoint 0 (OUT)
    usb_push(2'd0, 16'h1111);
    usb_push(2'd0, 16'h2222);
    usb_push(2'd0, 16'h3333);
    bus_read(3'd0, 1'b0, rd);
    bus_read(3'd0, 1'b0, rd);
    check("R4 peek keeps head", rd, 16'h1111);
    bad = 0;
    for (int k = 0; k < 3; k++) begin
      bus_read(3'd0, 1'b1, rd);
      if (rd !== 16'h1111 * 16'(k + 1)) bad++;
    end
    check("R4 master pop order", bad, 0);
    addr_i = 3'd0;
    #1 check("R6 empty after drain", {flag_b_o, flag_c_o}, 2'b01);
    // R7: read from empty ignored
    bus_read(3'd0, 1'b1, rd);
    usb_push(2'd0, 16'h4444);
    bus_read(3'd0, 1'b1, rd);
    check("R7 empty read ignored", rd, 16'h4444);

    // R6, R7, R8 on endpoint 3 (IN), threshold is 5
    for (int k = 0; k < 512; k++) begin
      bus_write(3'd3, 16'h4000 + 16'(k));
      #1;
      if (k == 3) check("R6 level below thresh", flag_a_o, 1'b0);
      if (k == 4) check("R8 level at thresh", flag_a_o, 1'b1);
    end
    #1 check("R6 full flags", {flag_b_o, flag_c_o}, 2'b10);
    bus_write(3'd3, 16'hDEAD);
    commit(3'd3);
    usb_ep_i = 2'd3;
    bad = 0;
    for (int k = 0; k < 512; k++) begin
      @(negedge clk_i);
      #1 if (usb_data_o !== 16'h4000 + 16'(k)) bad++;
      usb_pop_i = 1'b1;
      @(negedge clk_i);
      usb_pop_i = 1'b0;
    end
    check("R7 full write ignored", bad, 0);
    addr_i = 3'd3;
    #1 check("R7 nothing extra stored", {usb_ready_o, flag_c_o}, 2'b01);

    // R10 and R11 interrupts
    bus_write(3'd4, 16'h0004);
    usb_event(6'b001000);
    check("R10 disabled event", int_no, 1'b1);
    usb_event(6'b000100);
    check("R10 enabled event", int_no, 1'b0);
    bus_read(3'd4, 1'b1, rd);
    check("R11 status byte", rd, 16'h0004);
    #1 check("R11 cleared", int_no, 1'b1);
    bus_read(3'd4, 1'b1, rd);
    check("R11 back to register read", rd, 16'h0055);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule